// File: doc/BRIEF.md
# Two-Clock Line-Doubling Video Converter

This block takes a low-line-rate digital colour video stream (four colour bits, intensity, blue, green and red, plus horizontal and vertical sync levels) and turns it into a stream with twice the line rate. A pair of line stores take turns. The incoming scanline fills one store. The store holding the previous scanline is played back twice, back to back, on an output clock that runs at twice the sample rate. Sync levels are kept with every stored sample and come back out unchanged, so the output carries the input's sync shape at the doubled rate and no sync timing is generated.

Samples arrive on the write clock as a strobed stream. A sample is taken on every write-clock edge where `in_valid` is high, and ignored otherwise. The block always accepts data, so there is no ready signal and no back-pressure: a source may present a sample on any cycle. The output is a registered 6-bit word on the read clock that updates every read cycle. A scanline-darkening mode, selected by `scan_en`, blanks the colour bits of one of the two replayed copies of each line and passes its sync bits through.

Top module: `scandbl_top`

## Requirements
- R1: While reset is low and after its release, `out_word` is zero until a completed line with at least one stored sample has been played back.
- R2: A sample word has vsync at bit 5, hsync at bit 4 and the colour bits intensity, blue, green, red at bits 3, 2, 1, 0. It is captured on a rising `wclk` edge when `in_valid` is high.
- R3: A captured sample with hsync 1, following a captured sample with hsync 0 (or the first captured sample after reset, if its hsync is 1), starts a new line. That sample is stored at address 0 of the other store, and the line just closed keeps the count of samples stored in it.
- R4: Each closed line is replayed twice, back to back, one sample per `rclk` cycle, in address order. The first replayed word appears at `out_word` after the fifth `rclk` rising edge that follows the `wclk` edge which captured the line-start sample.
- R5: Replayed words equal the stored samples bit for bit, including both sync bits, whenever scanline mode does not apply.
- R6: A pass flag is 0 after reset and inverts at the start of each replay pass. When `scan_en` is high at the `rclk` edge that loads `out_word` and the flag is 1 for that word, the word is ANDed with 6'h30, which keeps sync and clears colour. On uninterrupted lines this applies to the first of the two passes.
- R7: A line holds at most DEPTH samples. Further samples of that line are dropped, and the line replays with DEPTH samples per pass.
- R8: After the second pass of a line ends, `out_word` is zero until the next playback. A line that closes with no stored samples produces no playback.
- R9: Cycles with `in_valid` low store nothing, do not advance the write position, and take no part in line-start detection, even when their hsync bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Sample (write) clock |
| rclk | input | 1 | Output (read) clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_valid | input | 1 | Sample strobe; the sample is taken when high |
| in_sample | input | 6 | {vsync, hsync, I, B, G, R} |
| scan_en | input | 1 | Scanline-darkening mode enable |
| out_word | output | 6 | Registered replayed word {vsync, hsync, I, B, G, R} |

## Verification
The fixed latency is the key quantity. A line-start sample captured on `wclk` crosses two synchronizer flops and one control register, spends one cycle in the store's registered read, and then passes through the output register. The first replayed word therefore appears five `rclk` edges after the last `rclk` edge that came before the capturing `wclk` edge. The bench offsets `wclk` from `rclk` by a quarter period so this count is unambiguous. Its model timestamps every line start with the running `rclk` count plus five, computes the expected word for each later edge, and compares the output at the following falling `rclk` edge. The scanline mask uses the `scan_en` value seen at the same rising edge that loads the word.

// File: rtl/scandbl_pkg.sv
package scandbl_pkg;
  localparam int SAMPLE_W = 6;
  localparam int VS_BIT   = 5;
  localparam int HS_BIT   = 4;
  localparam int NUM_BUF  = 2;
  typedef logic [SAMPLE_W-1:0] sample_t;
  localparam sample_t DIM_MASK  = 6'h30;
  localparam sample_t FULL_MASK = 6'h3f;
endpackage

// File: rtl/scandbl_bitsync.sv
module scandbl_bitsync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/scandbl_linebuf.sv
module scandbl_linebuf
  import scandbl_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  sample_t       wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output sample_t       rdata
);
  sample_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scandbl_wr.sv
module scandbl_wr
  import scandbl_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                 wclk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  sample_t              in_sample,
  output logic [NUM_BUF-1:0]   we,
  output logic [AW-1:0]        waddr,
  output sample_t              wdata,
  output logic                 wsel,
  output logic                 line_tog,
  output logic [LW-1:0]        len0,
  output logic [LW-1:0]        len1,
  output logic [LW-1:0]        wcnt
);
  logic          prev_hs;
  logic [LW-1:0] len_q [NUM_BUF];
  logic          rise;
  logic          room;

  assign rise  = in_valid && in_sample[HS_BIT] && !prev_hs;
  assign room  = wcnt < LW'(DEPTH);
  assign wdata = in_sample;
  assign len0  = len_q[0];
  assign len1  = len_q[1];

  always_comb begin
    we    = '0;
    waddr = '0;
    if (rise) begin
      we[~wsel] = 1'b1;
    end else if (in_valid && room) begin
      we[wsel] = 1'b1;
      waddr    = wcnt[AW-1:0];
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hs  <= 1'b0;
      wsel     <= 1'b0;
      line_tog <= 1'b0;
      wcnt     <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
    end else begin
      if (in_valid) prev_hs <= in_sample[HS_BIT];
      if (rise) begin
        wsel        <= ~wsel;
        line_tog    <= ~line_tog;
        len_q[wsel] <= wcnt;
        wcnt        <= LW'(1);
      end else if (in_valid && room) begin
        wcnt <= wcnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/scandbl_rd.sv
module scandbl_rd
  import scandbl_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 11
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          tog_s,
  input  logic          wsel_s,
  input  logic [LW-1:0] len0,
  input  logic [LW-1:0] len1,
  input  logic          scan_en,
  input  sample_t       rdata0,
  input  sample_t       rdata1,
  output logic [AW-1:0] raddr,
  output sample_t       out_word,
  output logic          pass_start,
  output logic          even,
  output logic          act,
  output logic [LW-1:0] rcnt,
  output logic [LW-1:0] lenr
);
  logic [1:0]    pass_q;
  logic          tog_d;
  logic          rsel, rsel_b, act_b, even_b;
  logic [LW-1:0] len_new;
  logic          line_go, pass_end;
  sample_t       rd_word;

  assign len_new    = wsel_s ? len0 : len1;
  assign line_go    = (tog_s != tog_d) && (len_new != '0);
  assign act        = pass_q != 2'd0;
  assign pass_end   = act && (rcnt + LW'(1) == lenr);
  assign pass_start = line_go || (pass_end && pass_q == 2'd1);
  assign raddr      = rcnt[AW-1:0];
  assign rd_word    = rsel_b ? rdata1 : rdata0;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d  <= 1'b0;
      pass_q <= 2'd0;
      rcnt   <= '0;
      lenr   <= '0;
      rsel   <= 1'b0;
      even   <= 1'b0;
    end else begin
      tog_d <= tog_s;
      if (line_go) begin
        pass_q <= 2'd1;
        rcnt   <= '0;
        rsel   <= ~wsel_s;
        lenr   <= len_new;
        even   <= ~even;
      end else if (pass_end) begin
        rcnt <= '0;
        if (pass_q == 2'd2) begin
          pass_q <= 2'd0;
        end else begin
          pass_q <= 2'd2;
          even   <= ~even;
        end
      end else if (act) begin
        rcnt <= rcnt + LW'(1);
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      act_b    <= 1'b0;
      even_b   <= 1'b0;
      rsel_b   <= 1'b0;
      out_word <= '0;
    end else begin
      act_b  <= act;
      even_b <= even;
      rsel_b <= rsel;
      if (act_b) out_word <= rd_word & ((scan_en && even_b) ? DIM_MASK : FULL_MASK);
      else       out_word <= '0;
    end
  end
endmodule

// File: rtl/scandbl_top.sv
module scandbl_top
  import scandbl_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [5:0] in_sample,
  input  logic       scan_en,
  output logic [5:0] out_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [NUM_BUF-1:0] we;
  logic [AW-1:0]      waddr, raddr;
  sample_t            wdata;
  sample_t            rdata_b [NUM_BUF];
  logic               wsel, line_tog, wsel_s, tog_s;
  logic [LW-1:0]      len0, len1, wcnt, rcnt, lenr;
  logic               pass_start, even, act;

  scandbl_wr #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .we(we), .waddr(waddr), .wdata(wdata), .wsel(wsel), .line_tog(line_tog),
    .len0(len0), .len1(len1), .wcnt(wcnt)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    scandbl_linebuf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
      .wclk(wclk), .we(we[g]), .waddr(waddr), .wdata(wdata),
      .rclk(rclk), .raddr(raddr), .rdata(rdata_b[g])
    );
  end

  scandbl_bitsync #(.W(2)) u_sync (
    .clk(rclk), .rst_n(rst_n), .d({wsel, line_tog}), .q({wsel_s, tog_s})
  );

  scandbl_rd #(.AW(AW), .LW(LW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .tog_s(tog_s), .wsel_s(wsel_s),
    .len0(len0), .len1(len1), .scan_en(scan_en),
    .rdata0(rdata_b[0]), .rdata1(rdata_b[1]), .raddr(raddr), .out_word(out_word),
    .pass_start(pass_start), .even(even), .act(act), .rcnt(rcnt), .lenr(lenr)
  );
endmodule

// File: rtl/scandbl_chk.sv
module scandbl_chk #(
  parameter int DEPTH = 1024,
  parameter int LW    = 11
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic [LW-1:0] wcnt,
  input logic [LW-1:0] rcnt,
  input logic [LW-1:0] lenr,
  input logic          act,
  input logic          pass_start,
  input logic          even,
  input logic [5:0]    out_word
);
  // R7: the write position never runs past the store depth
  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= LW'(DEPTH));

  // R4: playback reads stay inside the stored length
  assert_read_in_line_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    act |-> rcnt < lenr);

  // R4: every pass begins at address zero
  assert_pass_from_zero_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    pass_start |=> (rcnt == '0) && act);

  // R6: the pass flag inverts at every pass start
  assert_flag_flips_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    pass_start |=> even != $past(even));

  // R8: no playback two cycles earlier means a zero output word
  assert_idle_zero_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !act |=> ##1 (out_word == 6'h00));
endmodule

bind scandbl_top scandbl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wcnt(wcnt), .rcnt(rcnt),
  .lenr(lenr), .act(act), .pass_start(pass_start), .even(even),
  .out_word(out_word)
);

// File: tb/scandbl_top_test.sv
`timescale 1ns/1ps
module scandbl_top_test;
  localparam int DEPTH = 32;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, scan_en = 1'b0;
  logic [5:0] in_sample = 6'h00;
  logic [5:0] out_word;

  int vectors = 0, errors = 0, rcyc = 0;
  string req = "R1";

  scandbl_top #(.DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sample(in_sample), .scan_en(scan_en), .out_word(out_word)
  );

  always #5 rclk = ~rclk;                       // 100 MHz output clock
  initial begin #2.5; forever begin wclk = ~wclk; #10; end end

  // Behavioural model: lines captured as queues, each with a start stamp
  logic [5:0] cur_q [$];
  logic [5:0] ln_old [$], ln_new [$];
  int st_old = -1, st_new = -1;
  logic m_prev = 1'b0;

  always @(posedge wclk) begin
    if (rst_n && in_valid) begin
      if (in_sample[4] && !m_prev) begin
        if (cur_q.size() > 0) begin           // R3 and R8: empty lines never play
          ln_old = ln_new; st_old = st_new;
          ln_new = cur_q;  st_new = rcyc + 5; // R4 latency
        end
        cur_q = {};
        cur_q.push_back(in_sample);
      end else if (cur_q.size() < DEPTH) begin // R7 drop past depth
        cur_q.push_back(in_sample);
      end
      m_prev = in_sample[4];
    end
  end

  logic [5:0] exp_w;
  string phase;
  always @(posedge rclk) begin
    int st, len, idx;
    rcyc++;
    if (st_new >= 0 && rcyc >= st_new) begin st = st_new; len = ln_new.size(); end
    else begin st = st_old; len = ln_old.size(); end
    exp_w = 6'h00; phase = "R8";
    if (st >= 0 && rcyc >= st && rcyc < st + 2 * len) begin
      idx   = rcyc - st;
      exp_w = (st == st_new) ? ln_new[idx % len] : ln_old[idx % len];
      phase = "R5";
      if (idx < len && scan_en) begin exp_w = exp_w & 6'h30; phase = "R6"; end
    end
  end

  always @(negedge rclk) begin
    vectors++;
    if (out_word !== exp_w) begin
      errors++;
      $display("FAIL %s/%s cycle %0d: out_word=%h expected=%h", req, phase, rcyc, out_word, exp_w);
    end
  end

  task automatic put(input logic v, input logic [5:0] s);
    @(negedge wclk);
    in_valid  = v;
    in_sample = s;
  endtask

  // R2 layout: {vs, hs, I, B, G, R}; hsync high for the first two samples
  task automatic send_line(input int n, input int seed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [5:0] s;
      s = {seed[0], (i < 2) ? 1'b1 : 1'b0, 4'((seed + 3 * i) % 16)};
      if (gaps) put(1'b0, 6'h1f);             // R9: invalid cycle with hsync set
      put(1'b1, s);
    end
  endtask

  initial begin
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    repeat (6) @(negedge rclk);
    vectors++;                                  // R1 explicit reset-state check
    if (out_word !== 6'h00) begin
      errors++;
      $display("FAIL R1: out_word=%h expected=00", out_word);
    end
    req = "R2,R3,R4,R5";
    send_line(12, 1, 0);
    send_line(12, 6, 0);
    send_line(12, 9, 0);
    req = "R6";
    scan_en = 1'b1;
    send_line(10, 4, 0);
    send_line(10, 13, 0);
    send_line(10, 2, 0);
    req = "R7";
    scan_en = 1'b0;
    send_line(40, 5, 0);
    send_line(12, 7, 0);
    req = "R9";
    send_line(14, 11, 1);
    send_line(12, 3, 0);
    req = "R8";
    put(1'b1, 6'h10);
    put(1'b0, 6'h00);
    repeat (150) @(negedge rclk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule